// File: doc/BRIEF.md
# CSMA/CA Backoff Engine

This block decides when one of several transmit queues may put a frame on the air under carrier-sense multiple access with collision avoidance. Each queue raises a start request. The engine serves the lowest-numbered requesting queue. It waits for the medium to stay idle for an interframe space, and after a busy medium or a failed attempt it counts down a random number of slots. It then grants the queue until the acknowledgement logic reports the result of the attempt.

The timing values come from software fields: the normal and extended interframe spaces, the slot length, a window after a receive decode during which a busy medium is ignored, and two lead times for transmit preparation. Per-queue contention-window exponents are packed into one word. A mode bit either adapts the window or pins it to a fixed value. When a packet ends, the engine emits a five-bit status word and keeps two values readable: the number of slots drawn for the last attempt and the window exponent that attempt used.

All microsecond fields are scaled by the parameter `US_CYC`, the number of clock cycles per microsecond. In the requirements below, a cycle count written as a µs field means that field times `US_CYC`.

Top module: `csma_backoff_engine`

## Requirements
- R1: While reset is active, `grant`, `tx_prep` and `done` are 0, and after reset `status`, `bo_slots` and `cw_used` read 0.
- R2: With several requests set, the lowest-numbered queue is granted. `grant` is one-hot and holds until an ACK result arrives.
- R3: When the medium is idle and no backoff is pending, `grant` rises on the (IFS+2)-th rising edge counted from the edge that first sees the request. IFS is `difs_us` when `csma_cfg[30]` is 1 and 0 when it is 0.
- R4: When `csma_cfg[29]` is 1, an `rx_err` pulse makes the next deferral use `eifs_us` instead of the normal space. Once one deferral has completed, the normal space applies again.
- R5: A first attempt whose deferral never saw a busy medium enters no contention, and both `bo_slots` and `cw_used` read 0. If a busy medium was seen, the attempt draws a backoff.
- R6: The drawn slot count lies in 0..2^CW−1. Counted from the edge on which the medium goes idle, the grant comes IFS+1+slots·`slot_us` cycles later. A busy medium during backoff freezes the remaining count, which resumes after a fresh interframe space.
- R7: `nav_busy` counts as a busy medium only when `csma_cfg[31]` is 1.
- R8: An `rx_done` pulse makes the engine ignore `chan_busy` for `csma_cfg[7:0]` microseconds.
- R9: `tx_prep` is high during the last `adv_cfg[7:0]` microseconds of a deferral that leads directly to transmission. It is also high during the last `adv_cfg[15:8]` microseconds of a backoff. It is never high while a grant is active.
- R10: On `ack_ok` during a grant, `done` pulses once with `status[4]`=0 and `status[3:0]` equal to the number of attempts made.
- R11: On `ack_timeout`, the engine retries while the attempt count is below the limit. At the limit, `done` pulses with `status[4]`=1 and `status[3:0]` equal to that limit. The limit is `retry_ovr` when nonzero, otherwise `pkt_retry_lim`; a limit of 0 acts as 1.
- R12: Queue n takes its minimum exponent from `cw_cfg[8n+3:8n]` and its maximum from `cw_cfg[8n+7:8n+4]`. With `csma_cfg[28]`=1, the exponent starts at the minimum and rises by one per timeout, up to the maximum. With `csma_cfg[28]`=0, every attempt uses `cw_cfg[3:0]`.
- R13: `ack_ok` and `ack_timeout` arriving while no grant is active are ignored: `done` stays 0 and `status` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csma_cfg | input | 32 | [31] NAV enable, [30] DIFS enable, [29] EIFS enable, [28] dynamic CW, [7:0] forced idle µs |
| cw_cfg | input | 8*NQ | Per-queue CW exponents, min in low nibble, max in high nibble |
| adv_cfg | input | 16 | [7:0] DIFS advance µs, [15:8] backoff advance µs |
| difs_us | input | 8 | Normal interframe space in µs |
| eifs_us | input | 8 | Extended interframe space in µs |
| slot_us | input | 8 | Slot length in µs |
| retry_ovr | input | 4 | Attempt-limit override, 0 means use per-packet limit |
| pkt_retry_lim | input | 4 | Per-packet attempt limit, sampled at packet start |
| chan_busy | input | 1 | Medium busy level |
| nav_busy | input | 1 | Virtual carrier busy level |
| rx_done | input | 1 | Receive decode completed pulse |
| rx_err | input | 1 | Erroneous reception pulse |
| req | input | NQ | Start request per queue |
| ack_ok | input | 1 | ACK received pulse |
| ack_timeout | input | 1 | ACK missing pulse |
| grant | output | NQ | One-hot transmit grant |
| tx_prep | output | 1 | Transmit preparation lead |
| done | output | 1 | Packet finished pulse |
| status | output | 5 | [4] no ACK, [3:0] attempts |
| bo_slots | output | 16 | Slots drawn in the last attempt |
| cw_used | output | 4 | CW exponent of the last attempt, 0 if no contention |

## Verification
The latency of each result is derived from the registered state path. With an idle medium, a grant is due IFS+2 edges after the request. After the medium goes idle it is due IFS+1+slots·slot cycles later, and `done` and `status` appear on the edge that samples the ACK pulse. The bench drives inputs just after the falling edge, samples just after each falling edge, and counts rising edges from the stimulus. It compares the count with the figure computed from these formulas, using the slot count the block reports at grant time. Prepare-lead windows are checked by counting the sampled cycles in which `tx_prep` was high before the grant.

// File: rtl/csma_backoff_engine.sv
module csma_backoff_engine #(
  parameter int          NQ        = 4,
  parameter int          US_CYC    = 10,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     csma_cfg,
  input  logic [8*NQ-1:0] cw_cfg,
  input  logic [15:0]     adv_cfg,
  input  logic [7:0]      difs_us,
  input  logic [7:0]      eifs_us,
  input  logic [7:0]      slot_us,
  input  logic [3:0]      retry_ovr,
  input  logic [3:0]      pkt_retry_lim,
  input  logic            chan_busy,
  input  logic            nav_busy,
  input  logic            rx_done,
  input  logic            rx_err,
  input  logic [NQ-1:0]   req,
  input  logic            ack_ok,
  input  logic            ack_timeout,
  output logic [NQ-1:0]   grant,
  output logic            tx_prep,
  output logic            done,
  output logic [4:0]      status,
  output logic [15:0]     bo_slots,
  output logic [3:0]      cw_used
);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int TW = 8 + $clog2(US_CYC + 1);
  localparam int SW = 16;
  localparam int RW = SW + TW;

  typedef enum logic [1:0] {S_IDLE, S_DEFER, S_BO, S_TX} state_t;

  state_t          st;
  logic [QW-1:0]   qsel, sel;
  logic [TW-1:0]   cnt, bcnt, fi_cnt;
  logic [3:0]      att, lim, cw_cur;
  logic            eifs_pend, saw_busy, drawn;
  logic [SW-1:0]   slots_left, lfsr;

  always_comb begin
    sel = '0;
    for (int i = NQ - 1; i >= 0; i--)
      if (req[i]) sel = QW'(i);
  end

  wire             busy_eff = (chan_busy & (fi_cnt == '0)) | (csma_cfg[31] & nav_busy);
  wire             use_eifs = csma_cfg[29] & eifs_pend;
  wire [TW-1:0]    ifs_cyc  = use_eifs     ? TW'(eifs_us) * TW'(US_CYC) :
                              csma_cfg[30] ? TW'(difs_us) * TW'(US_CYC) : '0;
  wire [TW-1:0]    slot_cyc = TW'(slot_us) * TW'(US_CYC);
  wire [TW-1:0]    slot_end = (slot_cyc == '0) ? '0 : slot_cyc - 1'b1;
  wire [TW-1:0]    adv_d    = TW'(adv_cfg[7:0]) * TW'(US_CYC);
  wire [TW-1:0]    adv_b    = TW'(adv_cfg[15:8]) * TW'(US_CYC);
  wire [3:0]       q_max    = cw_cfg[8*qsel+4 +: 4];
  wire [3:0]       cw_eff   = csma_cfg[28] ? cw_cur : cw_cfg[3:0];
  wire [SW:0]      cw_mask  = (17'd1 << cw_eff) - 17'd1;
  wire [SW-1:0]    draw     = lfsr & cw_mask[SW-1:0];
  wire             need_bo  = saw_busy | (att != 4'd0) | drawn;
  wire [3:0]       lim_pick = (retry_ovr != 4'd0) ? retry_ovr : pkt_retry_lim;
  wire [3:0]       att_nx   = att + 4'd1;
  wire [TW:0]      rem_d    = {1'b0, ifs_cyc} - {1'b0, cnt} + 1'b1;
  wire [RW-1:0]    rem_b    = RW'(slots_left) * RW'(slot_cyc) - RW'(bcnt);
  wire             defer_end = (st == S_DEFER) && !busy_eff && (cnt >= ifs_cyc);

  assign grant   = (st == S_TX) ? (NQ'(1) << qsel) : '0;
  assign tx_prep = ((st == S_DEFER) && !need_bo && (rem_d <= {1'b0, adv_d})) ||
                   ((st == S_BO) && (rem_b <= RW'(adv_b)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr      <= LFSR_SEED;
      fi_cnt    <= '0;
      eifs_pend <= 1'b0;
    end else begin
      lfsr <= {1'b0, lfsr[SW-1:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      if (rx_done)              fi_cnt <= TW'(csma_cfg[7:0]) * TW'(US_CYC);
      else if (fi_cnt != '0)    fi_cnt <= fi_cnt - 1'b1;
      if (rx_err)               eifs_pend <= 1'b1;
      else if (defer_end)       eifs_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  qsel <= '0;  cnt <= '0;  bcnt <= '0;
      att <= '0;  lim <= 4'd1;  cw_cur <= '0;  saw_busy <= 1'b0;  drawn <= 1'b0;
      slots_left <= '0;  bo_slots <= '0;  cw_used <= '0;
      done <= 1'b0;  status <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (|req) begin
          qsel     <= sel;
          att      <= '0;
          lim      <= (lim_pick == 4'd0) ? 4'd1 : lim_pick;
          cw_cur   <= cw_cfg[8*sel +: 4];
          saw_busy <= 1'b0;
          drawn    <= 1'b0;
          cnt      <= '0;
          bcnt     <= '0;
          bo_slots <= '0;
          cw_used  <= '0;
          st       <= S_DEFER;
        end
        S_DEFER: begin
          if (busy_eff) begin
            cnt      <= '0;
            saw_busy <= 1'b1;
          end else if (cnt >= ifs_cyc) begin
            cnt <= '0;
            if (!need_bo) st <= S_TX;
            else if (!drawn) begin
              drawn      <= 1'b1;
              slots_left <= draw;
              bo_slots   <= draw;
              cw_used    <= cw_eff;
              st         <= (draw == '0) ? S_TX : S_BO;
            end else st <= S_BO;
          end else cnt <= cnt + 1'b1;
        end
        S_BO: begin
          if (busy_eff) begin
            cnt <= '0;
            st  <= S_DEFER;
          end else if (bcnt >= slot_end) begin
            bcnt       <= '0;
            slots_left <= slots_left - 1'b1;
            if (slots_left == 16'd1) st <= S_TX;
          end else bcnt <= bcnt + 1'b1;
        end
        S_TX: begin
          if (ack_ok) begin
            done   <= 1'b1;
            status <= {1'b0, att_nx};
            st     <= S_IDLE;
          end else if (ack_timeout) begin
            if (att_nx >= lim) begin
              done   <= 1'b1;
              status <= {1'b1, att_nx};
              st     <= S_IDLE;
            end else begin
              att      <= att_nx;
              if (csma_cfg[28] && cw_cur < q_max) cw_cur <= cw_cur + 4'd1;
              drawn    <= 1'b0;
              saw_busy <= 1'b0;
              cnt      <= '0;
              bcnt     <= '0;
              st       <= S_DEFER;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csma_backoff_engine_chk.sv
module csma_backoff_engine_chk #(
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] grant,
  input logic          tx_prep,
  input logic          done,
  input logic [4:0]    status,
  input logic [15:0]   bo_slots,
  input logic [3:0]    cw_used,
  input logic          ack_ok,
  input logic          ack_timeout
);
  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && !ack_ok && !ack_timeout) |=> (grant == $past(grant)));

  p_done_follows_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(|grant));

  p_attempts_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status[3:0] != 4'd0));

  p_prep_off_in_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> !tx_prep);

  p_slots_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ({1'b0, bo_slots} <= ((17'd1 << cw_used) - 17'd1)));

  p_ack_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !done);
endmodule

bind csma_backoff_engine csma_backoff_engine_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .tx_prep(tx_prep), .done(done),
  .status(status), .bo_slots(bo_slots), .cw_used(cw_used),
  .ack_ok(ack_ok), .ack_timeout(ack_timeout)
);

// File: tb/csma_backoff_engine_test.sv
module csma_backoff_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int US  = 2;
  localparam int NQ  = 4;
  localparam int IFS = 3 * US;
  localparam int SLOT = 2 * US;

  // {difs_us, difs_adv_us, difs_en, expected latency, expected prep cycles}
  localparam logic [32:0] VEC [4] = '{
    {8'd3, 8'd1, 1'b1, 8'd8,  8'd2},
    {8'd5, 8'd0, 1'b1, 8'd12, 8'd0},
    {8'd4, 8'd2, 1'b0, 8'd2,  8'd1},
    {8'd2, 8'd9, 1'b1, 8'd6,  8'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] csma_cfg = 32'h5000_0000;
  logic [31:0] cw_cfg = 32'h5221_4331;
  logic [15:0] adv_cfg = '0;
  logic [7:0]  difs_us = 8'd3, eifs_us = 8'd8, slot_us = 8'd2;
  logic [3:0]  retry_ovr = '0, pkt_retry_lim = 4'd4;
  logic chan_busy = 0, nav_busy = 0, rx_done = 0, rx_err = 0, ack_ok = 0, ack_timeout = 0;
  logic [NQ-1:0] req = '0;
  logic [NQ-1:0] grant;
  logic tx_prep, done;
  logic [4:0] status;
  logic [15:0] bo_slots;
  logic [3:0] cw_used;

  int total = 0, bad = 0;

  csma_backoff_engine #(.NQ(NQ), .US_CYC(US)) uut (
    .clk(clk), .rst_n(rst_n), .csma_cfg(csma_cfg), .cw_cfg(cw_cfg), .adv_cfg(adv_cfg),
    .difs_us(difs_us), .eifs_us(eifs_us), .slot_us(slot_us), .retry_ovr(retry_ovr),
    .pkt_retry_lim(pkt_retry_lim), .chan_busy(chan_busy), .nav_busy(nav_busy),
    .rx_done(rx_done), .rx_err(rx_err), .req(req), .ack_ok(ack_ok),
    .ack_timeout(ack_timeout), .grant(grant), .tx_prep(tx_prep), .done(done),
    .status(status), .bo_slots(bo_slots), .cw_used(cw_used)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic run(output int n, output int p);
    n = 0; p = 0;
    do begin
      tick();
      n++;
      if (tx_prep) p++;
    end while (grant == '0 && n < 500);
  endtask

  task automatic ack(input bit ok, output logic d, output logic [4:0] s);
    if (ok) ack_ok = 1'b1; else ack_timeout = 1'b1;
    tick();
    d = done; s = status;
    ack_ok = 1'b0; ack_timeout = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, p, s;
    logic d;
    logic [4:0] st;

    repeat (3) tick();
    chk("R1 grant in reset", int'(grant), 0);
    chk("R1 prep in reset", int'(tx_prep), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 status after reset", int'(status), 0);
    chk("R1 slots after reset", int'(bo_slots), 0);
    chk("R1 cw after reset", int'(cw_used), 0);

    // R3 / R9 table: idle deferral latency and DIFS advance
    for (int i = 0; i < 4; i++) begin
      logic [32:0] e;
      e = VEC[i];
      difs_us = e[32:25];
      adv_cfg = {8'd0, e[24:17]};
      csma_cfg[30] = e[16];
      req = 4'b0001;
      run(n, p);
      req = '0;
      chk("R3 idle latency", n, int'(e[15:8]));
      chk("R9 difs advance cycles", p, int'(e[7:0]));
      chk("R5 no contention cw", int'(cw_used), 0);
      ack(1'b1, d, st);
      chk("R10 done on ack", int'(d), 1);
      chk("R10 status one attempt", int'(st), 5'h01);
    end
    difs_us = 8'd3; adv_cfg = '0; csma_cfg = 32'h5000_0000;

    // R2 priority
    req = 4'b0110;
    run(n, p);
    chk("R2 lowest index granted", int'(grant), 4'b0010);
    req = 4'b0100;
    ack(1'b1, d, st);
    run(n, p);
    chk("R2 next queue granted", int'(grant), 4'b0100);
    req = '0;
    ack(1'b1, d, st);

    // R4 EIFS
    csma_cfg = 32'h7000_0000;
    rx_err = 1'b1; tick(); rx_err = 1'b0;
    req = 4'b0001; run(n, p); req = '0;
    chk("R4 eifs deferral", n, 8 * US + 2);
    ack(1'b1, d, st);
    req = 4'b0001; run(n, p); req = '0;
    chk("R4 eifs cleared", n, IFS + 2);
    ack(1'b1, d, st);
    csma_cfg = 32'h5000_0000;

    // R8 forced idle after decode
    csma_cfg[7:0] = 8'd10;
    chan_busy = 1'b1;
    rx_done = 1'b1; tick(); rx_done = 1'b0;
    req = 4'b0001; run(n, p); req = '0;
    chk("R8 busy masked latency", n, IFS + 2);
    chk("R8 no contention", int'(cw_used), 0);
    ack(1'b1, d, st);
    chan_busy = 1'b0; csma_cfg[7:0] = 8'd0;

    // R7 NAV
    nav_busy = 1'b1;
    req = 4'b0001; run(n, p); req = '0;
    chk("R7 nav ignored when disabled", n, IFS + 2);
    ack(1'b1, d, st);
    csma_cfg[31] = 1'b1;
    req = 4'b0001;
    s = 0;
    for (int k = 0; k < 30; k++) begin tick(); if (grant != '0) s++; end
    chk("R7 nav holds off grant", s, 0);
    nav_busy = 1'b0;
    run(n, p); req = '0;
    chk("R7 latency after nav", n, IFS + 1 + int'(bo_slots) * SLOT);
    chk("R12 dynamic starts at min", int'(cw_used), 1);
    ack(1'b1, d, st);
    csma_cfg[31] = 1'b0;

    // R6 / R9 / R12 fixed window, backoff advance
    csma_cfg = 32'h4000_0000;
    adv_cfg = {8'd3, 8'd0};
    chan_busy = 1'b1;
    req = 4'b1000;
    repeat (5) tick();
    chk("R5 no grant while busy", int'(grant), 0);
    chan_busy = 1'b0;
    run(n, p); req = '0;
    chk("R2 queue three granted", int'(grant), 4'b1000);
    chk("R6 backoff latency", n, IFS + 1 + int'(bo_slots) * SLOT);
    chk("R9 backoff advance cycles", p, (int'(bo_slots) * SLOT < 3 * US) ? int'(bo_slots) * SLOT : 3 * US);
    chk("R12 fixed uses low nibble", int'(cw_used), 1);
    chk("R6 slots in window", int'(bo_slots <= 16'd1), 1);
    ack(1'b0, d, st);
    chk("R11 retry no done", int'(d), 0);
    run(n, p);
    chk("R12 fixed not adapted", int'(cw_used), 1);
    ack(1'b1, d, st);
    chk("R10 status two attempts", int'(st), 5'h02);
    adv_cfg = '0;

    // R6 freeze during backoff
    csma_cfg = 32'h5000_0000;
    chan_busy = 1'b1;
    req = 4'b0010;
    repeat (3) tick();
    chan_busy = 1'b0;
    n = 0;
    do begin
      tick();
      n++;
      if (grant != '0) break;
      if (n == IFS + 2) chan_busy = 1'b1;
      if (n == IFS + 2 + 5) chan_busy = 1'b0;
    end while (n < 500);
    req = '0;
    chk("R12 queue one min exponent", int'(cw_used), 3);
    if (bo_slots == 16'd0) chk("R6 zero slots latency", n, IFS + 1);
    else chk("R6 frozen backoff latency", n, 2 * IFS + 2 + 5 + int'(bo_slots) * SLOT);
    ack(1'b1, d, st);

    // R11 / R12 dynamic growth and limit
    pkt_retry_lim = 4'd3;
    req = 4'b0100; run(n, p); req = '0;
    chk("R5 first attempt idle", int'(cw_used), 0);
    ack(1'b0, d, st);
    run(n, p);
    chk("R12 cw grows", int'(cw_used), 2);
    ack(1'b0, d, st);
    run(n, p);
    chk("R12 cw capped at max", int'(cw_used), 2);
    ack(1'b0, d, st);
    chk("R11 done at limit", int'(d), 1);
    chk("R11 status no ack", int'(st), 5'h13);

    // R11 override
    retry_ovr = 4'd2; pkt_retry_lim = 4'd5;
    req = 4'b0001; run(n, p); req = '0;
    ack(1'b0, d, st);
    run(n, p);
    ack(1'b0, d, st);
    chk("R11 override limit", int'(st), 5'h12);
    retry_ovr = 4'd0;

    // R10 / R12 success after one retry
    req = 4'b0001; run(n, p); req = '0;
    ack(1'b0, d, st);
    run(n, p);
    chk("R12 cw min plus one", int'(cw_used), 2);
    ack(1'b1, d, st);
    chk("R10 success status", int'(st), 5'h02);

    // R13 ack pulses while idle
    ack(1'b1, d, st);
    chk("R13 ack_ok ignored", int'(d), 0);
    ack(1'b0, d, st);
    chk("R13 timeout ignored", int'(d), 0);
    chk("R13 status kept", int'(st), 5'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule